// File: doc/BRIEF.md
# I2C START/STOP condition detector

This block watches the SCL and SDA lines of an I2C bus and reports START and STOP conditions. It accepts a condition only when the bus timing is clean. SCL must have been high for a minimum setup interval when SDA changes. SCL must then stay high for a minimum hold interval after the change. Both intervals are counted in system clock cycles and come from one programmable 5-bit set value. The same value also gives an SCL release interval, which is provided on an output for the surrounding controller. Because the counting is in clock cycles, the absolute times scale with the clock frequency.

The control register also holds a pin select and a polarity select. Together they steer one edge interrupt from either SCL or SDA. The interrupt request is sticky and software clears it. A change to the pin select, the polarity select or the interface enable can raise the request by itself, because the request follows the rise of an effective level that depends on all three. Software is expected to clear the request after such a change.

Top module: `i2c_cond_det`

## Requirements
- R1: The control register resets to 0x00. A write stores wdata[4:0] as the set value, wdata[5] as the polarity select and wdata[6] as the pin select. Bit 7 always reads 0, so a write of 0xFF reads back 0x7F.
- R2: With legal set value S, a START pulse is produced when SDA falls after SCL has been high for at least S+1 cycles, and SCL then stays high for at least S/2 cycles. The pulse on start_o is one cycle wide.
- R3: If SDA changes when SCL has been high for fewer than S+1 cycles, neither start_o nor stop_o pulses.
- R4: If SCL falls before S/2 cycles have passed since the SDA change, the condition is dropped and no pulse is produced.
- R5: A STOP uses the same setup and hold check with SDA rising, and pulses stop_o. start_o and stop_o are never high together.
- R6: A set value that is zero or odd is used as the next lower even value, with a minimum of 2. For example, 7 acts as 6, 0 acts as 2 and 31 acts as 30.
- R7: rel_cyc_o equals S/2+1 for the legal set value S. For example, 26 gives 14, and the reset value gives 2.
- R8: Pin select 0 makes SDA the interrupt source, and 1 makes SCL the source. Edges on the pin that is not selected do not set the request.
- R9: Polarity select 0 sets the request on a falling edge of the source, and 1 sets it on a rising edge. Edges of the other direction do not set it.
- R10: irq_req_o stays set until irq_clr_i is high for one cycle. If a new edge and a clear fall in the same cycle, the request stays set.
- R11: The request follows the rise of the effective level, which is en_i AND (source XOR NOT polarity). So enabling the block, or a write to the pin or polarity select that makes this level rise, sets the request.
- R12: While en_i is low, no START or STOP is reported and the request is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | interface enable |
| scl_i | input | 1 | raw SCL line |
| sda_i | input | 1 | raw SDA line |
| ctrl_we_i | input | 1 | control register write strobe |
| ctrl_wdata_i | input | 8 | control register write data |
| ctrl_rdata_o | output | 8 | control register read value |
| irq_clr_i | input | 1 | clears the interrupt request |
| start_o | output | 1 | one-cycle START pulse |
| stop_o | output | 1 | one-cycle STOP pulse |
| rel_cyc_o | output | 6 | SCL release interval in cycles |
| irq_req_o | output | 1 | sticky edge-interrupt request |

## Verification
The new edge that sets the interrupt request and the software clear can land in the same cycle. The bench provokes this by timing irq_clr_i to reach the request register on the same clock edge as a synchronized SDA fall. It then expects the request to stay set. START and STOP detection is judged by a scoreboard that sorts pulses by kind. Each case sits exactly on a setup or hold boundary, or one cycle short of it.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int unsigned SET_W = 5;
  localparam int unsigned CNT_W = SET_W + 1;

  typedef struct packed {
    logic             pin_sel;
    logic             pol;
    logic [SET_W-1:0] set_val;
  } ctrl_t;

  function automatic logic [SET_W-1:0] legal_set(input logic [SET_W-1:0] v);
    logic [SET_W-1:0] e;
    e = {v[SET_W-1:1], 1'b0};
    return (e == '0) ? SET_W'(2) : e;
  endfunction
endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/cond_timer.sv
module cond_timer
  import i2c_cond_pkg::*;
(
  input  logic [SET_W-1:0] set_i,
  output logic [CNT_W-1:0] setup_cyc_o,
  output logic [CNT_W-1:0] hold_cyc_o,
  output logic [CNT_W-1:0] rel_cyc_o
);
  logic [SET_W-1:0] lv;
  assign lv          = legal_set(set_i);
  assign setup_cyc_o = {1'b0, lv} + CNT_W'(1);
  assign hold_cyc_o  = CNT_W'(lv >> 1);
  assign rel_cyc_o   = CNT_W'(lv >> 1) + CNT_W'(1);
endmodule

// File: rtl/cond_fsm.sv
module cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  output logic             start_o,
  output logic             stop_o
);
  typedef enum logic {ST_IDLE, ST_HOLD} st_e;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  st_e              st_q, st_d;
  logic             sda_q, kind_q, kind_d;
  logic [CNT_W-1:0] high_q, high_d, hold_q, hold_d;
  logic             sda_edge, setup_ok, fire, fire_stop;

  assign sda_edge = sda_s_i ^ sda_q;
  assign setup_ok = scl_s_i && (high_q >= setup_cyc_i);
  assign high_d   = !scl_s_i ? '0 : (high_q == CNT_MAX ? CNT_MAX : high_q + CNT_W'(1));

  always_comb begin
    st_d      = st_q;
    hold_d    = hold_q;
    kind_d    = kind_q;
    fire      = 1'b0;
    fire_stop = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (sda_edge && setup_ok) begin
          if (hold_cyc_i <= CNT_W'(1)) begin
            fire      = 1'b1;
            fire_stop = sda_s_i;
          end else begin
            st_d   = ST_HOLD;
            hold_d = CNT_W'(1);
            kind_d = sda_s_i;
          end
        end
        ST_HOLD: begin
          if (!scl_s_i || sda_edge) begin
            st_d = ST_IDLE;
          end else if (hold_q + CNT_W'(1) >= hold_cyc_i) begin
            fire      = 1'b1;
            fire_stop = kind_q;
            st_d      = ST_IDLE;
          end else begin
            hold_d = hold_q + CNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sda_q   <= 1'b1;
      kind_q  <= 1'b0;
      high_q  <= '0;
      hold_q  <= '0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sda_q   <= sda_s_i;
      kind_q  <= kind_d;
      high_q  <= high_d;
      hold_q  <= hold_d;
      start_o <= fire & ~fire_stop;
      stop_o  <= fire & fire_stop;
    end
  end

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_setup_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sda_edge && !setup_ok) |=> (!start_o && !stop_o));
  assert_hold_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !scl_s_i) |=> (!start_o && !stop_o));
  assert_one_kind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/cond_irq.sv
module cond_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_sel_i,
  input  logic pol_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic clr_i,
  output logic req_o
);
  logic src, lvl, lvl_q, set;

  assign src = pin_sel_i ? scl_s_i : sda_s_i;
  assign lvl = en_i & (pol_i ? src : ~src);
  assign set = lvl & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      req_o <= 1'b0;
    end else begin
      lvl_q <= lvl;
      req_o <= set | (req_o & ~clr_i);
    end
  end

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !clr_i) |=> req_o);
  assert_edge_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl) |=> req_o);
  assert_off_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !req_o) |=> !req_o);
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
  import i2c_cond_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  output logic [7:0]       ctrl_rdata_o,
  input  logic             irq_clr_i,
  output logic             start_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] rel_cyc_o,
  output logic             irq_req_o
);
  ctrl_t            ctrl_q;
  logic [1:0]       bus_s;
  logic [CNT_W-1:0] setup_cyc, hold_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i[SET_W+1:0]);
  end
  assign ctrl_rdata_o = 8'(ctrl_q);

  cond_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  cond_timer u_timer (
    .set_i      (ctrl_q.set_val),
    .setup_cyc_o(setup_cyc),
    .hold_cyc_o (hold_cyc),
    .rel_cyc_o  (rel_cyc_o)
  );

  cond_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .setup_cyc_i(setup_cyc),
    .hold_cyc_i (hold_cyc),
    .start_o    (start_o),
    .stop_o     (stop_o)
  );

  cond_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pin_sel_i(ctrl_q.pin_sel),
    .pol_i    (ctrl_q.pol),
    .scl_s_i  (bus_s[1]),
    .sda_s_i  (bus_s[0]),
    .clr_i    (irq_clr_i),
    .req_o    (irq_req_o)
  );

  assert_bit7_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[7]);
  assert_rel_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_cyc_o >= CNT_W'(2));
  assert_setup_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup_cyc[0] == 1'b0 && setup_cyc >= CNT_W'(3));
  assert_en_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> $past(en_i));
endmodule

// File: tb/i2c_cond_det_tb.sv
`timescale 1ns/1ps
module i2c_cond_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, scl = 1'b1, sda = 1'b1, we = 1'b0, clr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       start_p, stop_p, req;
  logic [5:0] rel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic q_exp[$];

  always #4 clk = ~clk;

  i2c_cond_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_rdata_o(rdata),
    .irq_clr_i(clr), .start_o(start_p), .stop_o(stop_p),
    .rel_cyc_o(rel), .irq_req_o(req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lset(input int v);
    int e = v & 30;
    return (e == 0) ? 2 : e;
  endfunction

  // monitor: pop expected kind (0 start, 1 stop) per pulse
  always @(negedge clk) begin
    if (rst_n && (start_p || stop_p)) begin
      if (q_exp.size() == 0) check(1'b0, "R3 unexpected pulse", {30'd0, stop_p, start_p}, 0);
      else begin
        logic k;
        k = q_exp.pop_front();
        check(stop_p == k && start_p == !k, "R2/R5 pulse kind", {30'd0, stop_p, start_p}, k ? 2 : 1);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
    wait_n(3);
  endtask

  // is_stop=0: SDA falls; is_stop=1: SDA rises. n setup negedges, m hold negedges.
  task automatic cond_seq(input bit is_stop, input int n, input int m, input bit exp);
    @(negedge clk); scl = 1'b0; sda = is_stop ? 1'b0 : 1'b1;
    wait_n(3);
    if (exp) q_exp.push_back(is_stop);
    scl = 1'b1;
    wait_n(n);
    sda = ~sda;
    wait_n(m);
    scl = 1'b0;
    wait_n(10);
    check(q_exp.size() == 0, "R2/R4 missing pulse", q_exp.size(), 0);
    q_exp.delete();
  endtask

  task automatic clear_req();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    wait_n(3);
  endtask

  initial begin
    int s;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check(rdata == 8'h00, "R1 reset value", rdata, 0);
    check(rel == 6'd2, "R7 reset release", rel, 2);
    check(!start_p && !stop_p && !req, "R1 reset outputs", {start_p, stop_p, req}, 0);

    wr(8'hFF);
    check(rdata == 8'h7F, "R1 bit7 reads 0", rdata, 8'h7F);
    check(rel == 6'(lset(31) / 2 + 1), "R6 value 31 legal", rel, lset(31) / 2 + 1);
    wr(8'h1A);
    s = lset(26);
    check(rdata == 8'h1A, "R1 set field", rdata, 8'h1A);
    check(rel == 6'(s / 2 + 1), "R7 release 26", rel, s / 2 + 1);

    cond_seq(1'b0, s + 1, s / 2, 1'b1);     // R2 exact boundary
    cond_seq(1'b0, s, s / 2, 1'b0);         // R3 setup one short
    cond_seq(1'b0, s + 1, s / 2 - 1, 1'b0); // R4 hold one short
    cond_seq(1'b1, s + 1, s / 2, 1'b1);     // R5 stop
    cond_seq(1'b1, s, s / 2, 1'b0);         // R3 stop setup short

    wr(8'h07);
    s = lset(7);
    check(rel == 6'(s / 2 + 1), "R6 odd value 7", rel, s / 2 + 1);
    cond_seq(1'b0, s + 1, s / 2, 1'b1);     // R6
    cond_seq(1'b0, s, s / 2, 1'b0);         // R6
    wr(8'h00);
    s = lset(0);
    check(rel == 6'(s / 2 + 1), "R6 zero value", rel, s / 2 + 1);
    cond_seq(1'b0, s + 1, s / 2, 1'b1);     // R6 minimum hold of 1

    en = 1'b0;
    cond_seq(1'b0, s + 1, s / 2, 1'b0);     // R12
    cond_seq(1'b1, s + 1, s / 2, 1'b0);     // R12
    en = 1'b1;

    // interrupt: pin SDA, falling
    @(negedge clk); scl = 1'b0; sda = 1'b1;
    wait_n(4); clear_req();
    check(req == 1'b0, "R10 cleared", req, 0);
    sda = 1'b0; wait_n(5);
    check(req == 1'b1, "R8 R9 SDA falling sets", req, 1);
    clear_req();
    check(req == 1'b0, "R10 clear", req, 0);
    sda = 1'b1; wait_n(5);
    check(req == 1'b0, "R9 rising ignored", req, 0);
    wr(8'h20);
    wait_n(2);
    check(req == 1'b1, "R11 polarity write sets", req, 1);
    clear_req();
    sda = 1'b0; wait_n(5);
    check(req == 1'b0, "R9 falling ignored", req, 0);
    sda = 1'b1; wait_n(5);
    check(req == 1'b1, "R9 rising sets", req, 1);
    clear_req();
    wr(8'h60);
    wait_n(2);
    check(req == 1'b0, "R11 no rise no set", req, 0);
    sda = 1'b0; wait_n(5); sda = 1'b1; wait_n(5);
    check(req == 1'b0, "R8 SDA ignored on SCL", req, 0);
    scl = 1'b1; wait_n(5);
    check(req == 1'b1, "R8 SCL rising sets", req, 1);
    clear_req();
    scl = 1'b0;

    // set and clear in the same cycle
    wr(8'h00);
    clear_req();
    check(req == 1'b0, "R10 pre clear", req, 0);
    @(negedge clk); sda = 1'b0;
    @(negedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    wait_n(2);
    check(req == 1'b1, "R10 set wins", req, 1);
    clear_req();

    // enable gating and enable rise
    sda = 1'b1;
    en = 1'b0;
    wr(8'h20);
    clear_req();
    wait_n(3);
    check(req == 1'b0, "R12 disabled no request", req, 0);
    en = 1'b1; wait_n(3);
    check(req == 1'b1, "R11 enable sets", req, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule